// File: doc/BRIEF.md
# Double-Buffered Energy Histogram Builder

This block builds an energy spectrum for one detector channel. A trigger strobe brings a 20-bit energy value. The block maps it to one of 2048 bins: it subtracts a programmable floor and shifts the result right by a programmable amount. It then adds one to that bin's 32-bit counter in the working page.

There is a second page of the same size, the readout page. It holds the spectrum of the period that has just ended, and a host reads it through a simple read port while the next spectrum builds. A once-per-second strobe drives a seconds counter. When the programmed period has run out, the two pages change roles.

The page being handed over must be empty before it becomes the working page. It can be cleared in two ways:
- The hardware clears it during the last second of the period.
- The host clears it with a command.

In hold mode the block halts instead of swapping onto a page that has not been cleared. It stays halted until the host clears that page. At every swap the block also reports, for the finished page, the lowest and highest bins that received a trigger, and whether any trigger arrived at all. This lets readout be limited to the bins that hold data.

Top module: `hist_energy_dbuf`

## Requirements
- R1: The bin of an accepted trigger depends on the trigger energy and `cfg_emin`:
  - If the energy is below `cfg_emin`, the bin is 0.
  - Otherwise the bin is `(energy - cfg_emin) >> cfg_ebin`.
  - Any result above 2047 becomes bin 2047.
- R2: Each accepted trigger adds exactly one to its bin in the working page. This also holds for triggers to the same bin on consecutive cycles. A counter at 2^32-1 stays there.
- R3: Each `sec_strobe` advances `sec_count` by one. A strobe arriving when `sec_count` equals the period minus one is a swap, unless R8 halts the block. At a swap:
  - `page_toggle` inverts.
  - `cycle_count` increments.
  - `sec_count` returns to 0.
  A `cfg_meas_time` below 2 acts as 2.
- R4: `rd_data` shows the readout page, which is page `~page_toggle`, at address `rd_addr`. The data appears two clock edges after the address is presented.
- R5: At each swap, `first_bin`, `last_bin` and `page_nonempty` take the lowest occupied bin, the highest occupied bin and the any-trigger flag of the page just finished. If that page received no trigger, all three are 0.
- R6: A `clr_cmd` pulse while no clear is running starts a clear, in either clear mode. The clear:
  - writes zero to all 2048 bins of the readout page;
  - holds `clear_busy` at 1 for 2048 cycles;
  - makes `rd_data` read 0 while it runs.
  A `clr_cmd` during a clear is ignored.
- R7: With `cfg_user_clear` = 0, a strobe that brings `sec_count` to the period minus one starts a clear of the readout page automatically.
- R8: With `cfg_hold` = 1, a swap strobe halts the block if the readout page has not been cleared since the last swap. While halted:
  - `halted` is 1;
  - the page roles are frozen;
  - triggers are ignored.
  The cycle that completes the next clear performs the swap and resumes counting.
  With `cfg_hold` = 0 the block swaps regardless of whether the readout page was cleared.
- R9: After reset:
  - `page_toggle`, `sec_count`, `cycle_count` and the bin-report outputs are 0.
  - Both pages are cleared over 2048 cycles, with `clear_busy` at 1 throughout.
  - Triggers during that clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger strobe, one cycle per event |
| trig_energy | input | 20 | Energy of the trigger |
| sec_strobe | input | 1 | One-cycle pulse per second |
| cfg_emin | input | 20 | Energy floor subtracted before binning |
| cfg_ebin | input | 4 | Right shift that sets bin width |
| cfg_meas_time | input | 16 | Period length in seconds (minimum 2) |
| cfg_hold | input | 1 | 1: halt on a swap onto an uncleared page |
| cfg_user_clear | input | 1 | 1: host clears the readout page; 0: automatic |
| clr_cmd | input | 1 | Host pulse to clear the readout page |
| rd_addr | input | 11 | Bin address for host readout |
| rd_data | output | 32 | Counter of the addressed readout bin |
| first_bin | output | 11 | Lowest occupied bin of the finished page |
| last_bin | output | 11 | Highest occupied bin of the finished page |
| page_nonempty | output | 1 | Finished page received at least one trigger |
| page_toggle | output | 1 | Working page index, inverts at each swap |
| clear_busy | output | 1 | A page clear is running |
| halted | output | 1 | Stopped waiting for a clear (hold mode) |
| sec_count | output | 16 | Seconds elapsed in the current period |
| cycle_count | output | 32 | Number of swaps since reset |

## Verification
Some properties are checked on every cycle:
- An energy below the floor lands in bin 0.
- A counter update never wraps to zero.
- The read port returns zero in the cycle after a clear was running.
- A change of the page bit always comes with one more swap.
- A halt only follows a strobe taken in hold mode.
- The bin report keeps first not above last, and is all zero when the page is empty.
- An automatic clear starts only in automatic clear mode.

Other behaviours need the bench's scenarios:
- The actual bin contents after mixed random and boundary energies, including back-to-back hits on one bin.
- The clamping at both ends of the range.
- The exact strobe on which a swap or an automatic clear begins.
- Triggers being dropped during the reset clear and during a halt.
- The resumed swap once a clear ends.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Number of histogram pages; the role swap relies on exactly two.
  localparam int NUM_PAGES = 2;

  // Saturating increment of a bin counter.
  function automatic logic [31:0] sat_inc32(input logic [31:0] v);
    return (v == 32'hFFFF_FFFF) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/hist_binner.sv
module hist_binner #(
  parameter int NBINS = 2048,
  parameter int E_W   = 20,
  parameter int SH_W  = 4,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [E_W-1:0]   in_e,
  input  logic [E_W-1:0]   emin,
  input  logic [SH_W-1:0]  ebin,
  output logic             out_v,
  output logic [BIN_W-1:0] out_bin
);
  logic [E_W-1:0]   diff, shifted;
  logic [BIN_W-1:0] idx;

  always_comb begin
    diff    = in_e - emin;
    shifted = diff >> ebin;
    if (in_e < emin)                      idx = '0;
    else if (shifted[E_W-1:BIN_W] != '0)  idx = BIN_W'(NBINS - 1);
    else                                  idx = shifted[BIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v   <= 1'b0;
      out_bin <= '0;
    end else begin
      out_v   <= in_v;
      out_bin <= idx;
    end
  end

  // R1: energies under the floor go to the first bin
  a_r1_below_floor: assert property (@(posedge clk) disable iff (rst)
    (in_v && in_e < emin) |=> (out_v && out_bin == '0));
endmodule

// File: rtl/hist_page_ram.sv
module hist_page_ram #(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl #(
  parameter int NBINS = 2048,
  parameter int MT_W  = 16,
  parameter int CNT_W = 32,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_strobe,
  input  logic [MT_W-1:0]  meas_time,
  input  logic             hold_mode,
  input  logic             user_clear_mode,
  input  logic             clr_cmd,
  output logic             swap,
  output logic             tgl,
  output logic             clearing,
  output logic             clr_both,
  output logic [BIN_W-1:0] clr_addr,
  output logic             halted,
  output logic [MT_W-1:0]  sec_cnt,
  output logic [CNT_W-1:0] cyc_cnt
);
  logic [MT_W-1:0] eff_mt;
  logic clean, last_sec, init_clr, period_end, go_halt, clr_done, auto_go, clr_go;

  always_comb begin
    eff_mt     = (meas_time < MT_W'(2)) ? MT_W'(2) : meas_time;
    last_sec   = (sec_cnt == eff_mt - MT_W'(1));
    init_clr   = clearing && clr_both;
    period_end = sec_strobe && !halted && !init_clr && last_sec;
    go_halt    = period_end && hold_mode && !clean;
    clr_done   = clearing && (clr_addr == BIN_W'(NBINS - 1));
    swap       = (period_end && !(hold_mode && !clean)) || (halted && clr_done);
    auto_go    = sec_strobe && !halted && !init_clr && !last_sec && !user_clear_mode &&
                 (sec_cnt + MT_W'(1) == eff_mt - MT_W'(1));
    clr_go     = !clearing && (auto_go || clr_cmd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_both <= 1'b1;
      clr_addr <= '0;
      clean    <= 1'b0;
      halted   <= 1'b0;
      tgl      <= 1'b0;
      sec_cnt  <= '0;
      cyc_cnt  <= '0;
    end else begin
      if (clearing) begin
        clr_addr <= clr_addr + 1'b1;
        if (clr_done) begin
          clearing <= 1'b0;
          clr_both <= 1'b0;
          clean    <= 1'b1;
        end
      end else if (clr_go) begin
        clearing <= 1'b1;
        clr_addr <= '0;
      end
      if (swap) begin
        tgl     <= ~tgl;
        cyc_cnt <= cyc_cnt + 1'b1;
        sec_cnt <= '0;
        halted  <= 1'b0;
        clean   <= 1'b0;
      end else if (go_halt) begin
        halted <= 1'b1;
      end else if (sec_strobe && !halted && !init_clr) begin
        sec_cnt <= sec_cnt + 1'b1;
      end
    end
  end

  // R3: each page flip is one counted swap
  a_r3_flip_counted: assert property (@(posedge clk) disable iff (rst)
    (tgl != $past(tgl)) |-> (cyc_cnt == $past(cyc_cnt) + 1'b1));

  // R8: a halt only follows a strobe taken in hold mode
  a_r8_halt_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> ($past(hold_mode) && $past(sec_strobe)));

  // R7: a clear not requested by the host only starts in automatic mode
  a_r7_auto_only: assert property (@(posedge clk) disable iff (rst)
    ($rose(clearing) && !$past(clr_cmd)) |-> !$past(user_clear_mode));
endmodule

// File: rtl/hist_energy_dbuf.sv
module hist_energy_dbuf #(
  parameter int NBINS = 2048,
  parameter int E_W   = 20,
  parameter int SH_W  = 4,
  parameter int CNT_W = 32,
  parameter int MT_W  = 16,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_valid,
  input  logic [E_W-1:0]   trig_energy,
  input  logic             sec_strobe,
  input  logic [E_W-1:0]   cfg_emin,
  input  logic [SH_W-1:0]  cfg_ebin,
  input  logic [MT_W-1:0]  cfg_meas_time,
  input  logic             cfg_hold,
  input  logic             cfg_user_clear,
  input  logic             clr_cmd,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [BIN_W-1:0] first_bin,
  output logic [BIN_W-1:0] last_bin,
  output logic             page_nonempty,
  output logic             page_toggle,
  output logic             clear_busy,
  output logic             halted,
  output logic [MT_W-1:0]  sec_count,
  output logic [CNT_W-1:0] cycle_count
);
  import hist_pkg::*;

  logic             swap, tgl, clearing, clr_both, run;
  logic [BIN_W-1:0] clr_addr;
  logic             a_v;
  logic [BIN_W-1:0] a_bin;
  logic             b_v, b_pg;
  logic [BIN_W-1:0] b_bin;
  logic             w_v, w_pg;
  logic [BIN_W-1:0] w_addr;
  logic [CNT_W-1:0] w_data, cur, nxt;
  logic [CNT_W-1:0] pg_q [NUM_PAGES];
  logic             rd_sel_q;
  logic             trk_v, nx_v;
  logic [BIN_W-1:0] trk_lo, trk_hi, nx_lo, nx_hi;

  hist_ctrl #(.NBINS(NBINS), .MT_W(MT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sec_strobe(sec_strobe), .meas_time(cfg_meas_time),
    .hold_mode(cfg_hold), .user_clear_mode(cfg_user_clear), .clr_cmd(clr_cmd),
    .swap(swap), .tgl(tgl), .clearing(clearing), .clr_both(clr_both),
    .clr_addr(clr_addr), .halted(halted), .sec_cnt(sec_count), .cyc_cnt(cycle_count)
  );

  assign run = !halted && !(clearing && clr_both);

  hist_binner #(.NBINS(NBINS), .E_W(E_W), .SH_W(SH_W)) u_bin (
    .clk(clk), .rst(rst), .in_v(trig_valid && run), .in_e(trig_energy),
    .emin(cfg_emin), .ebin(cfg_ebin), .out_v(a_v), .out_bin(a_bin)
  );

  // Read-modify-write: stage A reads the working page, stage B writes back.
  always_comb begin
    cur = (w_v && w_pg == b_pg && w_addr == b_bin) ? w_data : pg_q[b_pg];
    nxt = (CNT_W == 32) ? CNT_W'(sat_inc32(32'(cur))) :
          ((cur == '1) ? cur : cur + 1'b1);
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic             clr_here, we;
    logic [BIN_W-1:0] wa, ra;
    logic [CNT_W-1:0] wd;
    always_comb begin
      clr_here = clearing && (clr_both || (1'(p) != tgl));
      we       = clr_here || (b_v && b_pg == 1'(p));
      wa       = clr_here ? clr_addr : b_bin;
      wd       = clr_here ? '0 : nxt;
      ra       = (1'(p) == tgl) ? a_bin : rd_addr;
    end
    hist_page_ram #(.DW(CNT_W), .AW(BIN_W)) u_ram (
      .clk(clk), .we(we), .waddr(wa), .wdata(wd), .raddr(ra), .rdata(pg_q[p])
    );
  end

  // Occupied-range tracker for the working page, merged with the bin in flight.
  always_comb begin
    nx_v  = trk_v | a_v;
    nx_lo = trk_lo;
    nx_hi = trk_hi;
    if (a_v) begin
      if (!trk_v || a_bin < trk_lo) nx_lo = a_bin;
      if (!trk_v || a_bin > trk_hi) nx_hi = a_bin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_v <= 1'b0;  b_pg <= 1'b0;  b_bin <= '0;
      w_v <= 1'b0;  w_pg <= 1'b0;  w_addr <= '0;  w_data <= '0;
      trk_v <= 1'b0;  trk_lo <= '0;  trk_hi <= '0;
      first_bin <= '0;  last_bin <= '0;  page_nonempty <= 1'b0;
      rd_sel_q <= 1'b1;  rd_data <= '0;
    end else begin
      b_v    <= a_v;
      b_pg   <= tgl;
      b_bin  <= a_bin;
      w_v    <= b_v;
      w_pg   <= b_pg;
      w_addr <= b_bin;
      w_data <= nxt;
      if (swap) begin
        first_bin     <= nx_v ? nx_lo : '0;
        last_bin      <= nx_v ? nx_hi : '0;
        page_nonempty <= nx_v;
        trk_v  <= 1'b0;
        trk_lo <= '0;
        trk_hi <= '0;
      end else begin
        trk_v  <= nx_v;
        trk_lo <= nx_lo;
        trk_hi <= nx_hi;
      end
      rd_sel_q <= ~tgl;
      rd_data  <= clearing ? '0 : pg_q[rd_sel_q];
    end
  end

  assign page_toggle = tgl;
  assign clear_busy  = clearing;

  // R2: a counter update never wraps back to zero
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    b_v |-> (nxt != '0));

  // R6: readout is zero in the cycle after a clear was running
  a_r6_zero_when_busy: assert property (@(posedge clk) disable iff (rst)
    clear_busy |=> (rd_data == '0));

  // R5: reported range is ordered, and all zero for an empty page
  a_r5_range_order: assert property (@(posedge clk) disable iff (rst)
    page_nonempty |-> (first_bin <= last_bin));
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    !page_nonempty |-> (first_bin == '0 && last_bin == '0));
endmodule

// File: tb/test_hist_energy_dbuf.sv
module test_hist_energy_dbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_valid = 1'b0;
  logic [19:0] trig_energy = '0;
  logic        sec_strobe = 1'b0;
  logic [19:0] cfg_emin = 20'd1000;
  logic [3:0]  cfg_ebin = 4'd2;
  logic [15:0] cfg_meas_time = 16'd2;
  logic        cfg_hold = 1'b0;
  logic        cfg_user_clear = 1'b1;
  logic        clr_cmd = 1'b0;
  logic [10:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [10:0] first_bin, last_bin;
  logic        page_nonempty, page_toggle, clear_busy, halted;
  logic [15:0] sec_count;
  logic [31:0] cycle_count;

  always #2.5 clk = ~clk;

  hist_energy_dbuf i_hist_energy_dbuf (
    .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_energy(trig_energy),
    .sec_strobe(sec_strobe), .cfg_emin(cfg_emin), .cfg_ebin(cfg_ebin),
    .cfg_meas_time(cfg_meas_time), .cfg_hold(cfg_hold), .cfg_user_clear(cfg_user_clear),
    .clr_cmd(clr_cmd), .rd_addr(rd_addr), .rd_data(rd_data), .first_bin(first_bin),
    .last_bin(last_bin), .page_nonempty(page_nonempty), .page_toggle(page_toggle),
    .clear_busy(clear_busy), .halted(halted), .sec_count(sec_count),
    .cycle_count(cycle_count)
  );

  int unsigned mdl [2][2048];
  int          checks = 0;
  int          errors = 0;
  int          wp = 0;
  bit          exp_v = 0;
  int          exp_lo = 0, exp_hi = 0;
  int          hit_list [$];
  bit          done = 0;

  function automatic int exp_bin(int e, int emin, int sh);
    int d;
    if (e < emin) return 0;
    d = (e - emin) >> sh;
    return (d > 2047) ? 2047 : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic trig(input int e, input bit counted);
    int b;
    trig_valid  = 1'b1;
    trig_energy = 20'(e);
    @(negedge clk);
    trig_valid  = 1'b0;
    if (counted) begin
      b = exp_bin(e, int'(cfg_emin), int'(cfg_ebin));
      mdl[wp][b]++;
      hit_list.push_back(b);
      if (!exp_v || b < exp_lo) exp_lo = b;
      if (!exp_v || b > exp_hi) exp_hi = b;
      exp_v = 1;
    end
  endtask

  task automatic strobe();
    sec_strobe = 1'b1;
    @(negedge clk);
    sec_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic model_swap();
    wp = wp ^ 1;
    exp_v = 0; exp_lo = 0; exp_hi = 0;
  endtask

  task automatic host_read(input int a, output logic [31:0] d);
    rd_addr = 11'(a);
    repeat (3) @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_bins(input string req);
    logic [31:0] d;
    foreach (hit_list[i]) begin
      host_read(hit_list[i], d);
      chk(req, d, mdl[wp ^ 1][hit_list[i]]);
    end
  endtask

  task automatic check_report(input string req);
    chk(req, 32'(page_nonempty), 32'(exp_v));
    chk(req, 32'(first_bin), exp_v ? exp_lo : 0);
    chk(req, 32'(last_bin), exp_v ? exp_hi : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] rep_lo, rep_hi;
    void'($urandom(32'd20240611));
    foreach (mdl[p, b]) mdl[p][b] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state and the initial clear of both pages
    chk("R9 busy after reset", 32'(clear_busy), 1);
    chk("R9 toggle after reset", 32'(page_toggle), 0);
    chk("R9 cycle after reset", cycle_count, 0);
    repeat (1500) @(negedge clk);
    trig(1400, 0);                       // bin 100, dropped during initial clear
    repeat (700) @(negedge clk);
    chk("R9 busy done", 32'(clear_busy), 0);
    chk("R9 sec after reset", 32'(sec_count), 0);
    chk("R9 nonempty after reset", 32'(page_nonempty), 0);
    host_read(5, d);
    chk("R9 readout zero", d, 0);

    // R1/R2: directed boundaries and back-to-back hits, floor 1000, shift 2
    hit_list.push_back(100);
    trig(500, 1);   trig(1000, 1);  trig(1007, 1);
    trig(1040, 1);  trig(1040, 1);  trig(1040, 1);
    trig(20'hFFFFF, 1); trig(1000 + 4 * 2047, 1); trig(1000 + 4 * 2048, 1);
    for (int i = 0; i < 40; i++) begin
      trig(1000 + $urandom_range(0, 1199), 1);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk("R1 below floor bin0 model", mdl[wp][0], 2);
    strobe();
    chk("R3 sec advance", 32'(sec_count), 1);
    chk("R3 no swap yet", 32'(page_toggle), 0);
    strobe();
    chk("R3 toggle at swap", 32'(page_toggle), 1);
    chk("R3 cycle at swap", cycle_count, 1);
    chk("R3 sec restart", 32'(sec_count), 0);
    check_report("R5 report after swap");
    model_swap();
    check_bins("R2 bin counts");
    host_read(0, d);     chk("R1 bin 0 clamp low", d, 2);
    host_read(2047, d);  chk("R1 bin 2047 clamp high", d, 3);
    host_read(10, d);    chk("R2 back-to-back bin 10", d, mdl[wp ^ 1][10]);
    host_read(100, d);   chk("R9 trigger in init clear ignored", d, mdl[wp ^ 1][100]);

    // R6: user clear of the readout page
    clr_cmd = 1'b1; @(negedge clk); clr_cmd = 1'b0;
    chk("R6 busy during clear", 32'(clear_busy), 1);
    host_read(10, d);
    chk("R6 reads zero while clearing", d, 0);
    repeat (2100) @(negedge clk);
    chk("R6 busy ends", 32'(clear_busy), 0);
    host_read(2047, d);
    chk("R6 bin cleared", d, 0);
    foreach (mdl[wp ^ 1][b]) mdl[wp ^ 1][b] = 0;

    // R3/R5: empty period, period setting 1 acts as 2
    cfg_meas_time = 16'd1;
    hit_list.delete();
    strobe();
    chk("R3 short period acts as 2", 32'(page_toggle), 1);
    strobe();
    chk("R3 swap after two strobes", 32'(page_toggle), 0);
    chk("R3 cycle two", cycle_count, 2);
    check_report("R5 empty report");
    model_swap();

    // R8: hold mode halts on an uncleared readout page
    cfg_meas_time = 16'd2; cfg_hold = 1'b1; cfg_emin = 20'd0; cfg_ebin = 4'd0;
    for (int i = 0; i < 20; i++) trig($urandom_range(100, 1999), 1);
    repeat (5) @(negedge clk);
    strobe(); strobe();
    chk("R8 halted", 32'(halted), 1);
    chk("R8 toggle frozen", 32'(page_toggle), 0);
    chk("R8 cycle frozen", cycle_count, 2);
    trig(50, 0);                          // ignored while halted
    hit_list.push_back(50);
    repeat (5) @(negedge clk);
    rep_lo = 32'(exp_lo); rep_hi = 32'(exp_hi);
    clr_cmd = 1'b1; @(negedge clk); clr_cmd = 1'b0;
    repeat (2100) @(negedge clk);
    chk("R8 resumed", 32'(halted), 0);
    chk("R8 swap on clear end", 32'(page_toggle), 1);
    chk("R8 cycle after resume", cycle_count, 3);
    chk("R5 first after resume", 32'(first_bin), rep_lo);
    chk("R5 last after resume", 32'(last_bin), rep_hi);
    model_swap();
    check_bins("R8 counts and dropped trigger");

    // R7: automatic clear in the last second, period 3
    cfg_hold = 1'b0; cfg_user_clear = 1'b0; cfg_meas_time = 16'd3;
    strobe();
    chk("R7 no clear before last second", 32'(clear_busy), 0);
    sec_strobe = 1'b1; @(negedge clk); sec_strobe = 1'b0;
    chk("R7 auto clear starts", 32'(clear_busy), 1);
    repeat (2100) @(negedge clk);
    host_read(hit_list[0], d);
    chk("R7 readout cleared", d, 0);
    foreach (mdl[wp ^ 1][b]) mdl[wp ^ 1][b] = 0;
    hit_list.delete();
    trig(77, 1); trig(77, 1); trig(900, 1);
    repeat (5) @(negedge clk);
    strobe();
    chk("R3 swap period 3", 32'(page_toggle), 0);
    chk("R3 cycle four", cycle_count, 4);
    check_report("R5 report period 3");
    model_swap();
    check_bins("R4 readout of other page");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule